// File: doc/BRIEF.md
# Five-Level Bus Grant Arbiter

This block decides which agent drives a shared bus next. Three classes of agent post requests. Each agent in a group of cache agents has a high-priority line and a low-priority line. Each agent in a group of memory agents has a single line. One display agent has a high-priority line and a low-priority line. Every request line is a post strobe. A strobe that is sampled high latches a pending entry. The entry stays pending until it is granted, and is then cleared. While an entry is pending, its own counter records how many cycles it has waited. An entry may compete only after that count reaches a configured threshold.

Arbitration takes place in a cycle where `busIdle` is high, which means the packet of the previous grant has finished. The five levels are ranked by fixed priority. Inside each level that holds several agents, a round-robin pointer decides the winner. The result appears one clock later on registered outputs. These are a one-hot grant vector, the binary ID of the winner and a valid flag. If nothing is eligible, a one-cycle no-op flag appears in their place.

Top module: `bus_class_arbiter`

## Requirements
- R1: Agent IDs are assigned as follows. Memory agents take IDs 0 to NUM_MEM-1. Cache agents take the next NUM_CACHE IDs in order. The display agent takes the highest ID, NUM_MEM+NUM_CACHE. Bit i of `grantVec` belongs to agent i, and `grantId` carries the same agent as a binary number.
- R2: Levels are ranked from highest to lowest in this order: cache high-priority, memory, display high-priority, cache low-priority, display low-priority. The highest level that has an eligible entry wins.
- R3: In the cache-high, memory and cache-low levels, the search begins at that level's pointer. It moves upward and wraps from the last agent of the group to the first.
- R4: When a level grants group member k, its pointer becomes k+1, wrapping to 0. The pointers of the other levels do not change. After reset, every pointer is 0.
- R5: A pending entry is eligible once its wait count reaches ARB_LATENCY. Suppose the strobe is sampled at edge E0 and `busIdle` stays high. Edges E0 through E0+ARB_LATENCY then produce no-ops. The grant is registered at edge E0+ARB_LATENCY+1.
- R6: A grant clears its entry. A single strobe therefore yields exactly one grant, and a later arbitration with no new strobe gives a no-op.
- R7: When `busIdle` is sampled high and no entry is eligible, `noOp` pulses for one cycle. During that cycle `grantVec` is 0 and `grantValid` is 0.
- R8: Results appear only in the cycle after `busIdle` was sampled high. While `busIdle` is low, all outputs stay 0 and pending entries are kept.
- R9: During reset and just after it, `grantVec`, `grantId`, `grantValid` and `noOp` are all 0.
- R10: While `grantValid` is high, `grantVec` has exactly one bit set, and that bit is the bit at `grantId`.
- R11: Suppose a strobe is sampled in the same cycle that its entry is granted. The grant is issued, and the strobe posts a fresh request whose wait count starts again from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busIdle | input | 1 | Bus free; arbitrate this cycle |
| memReq | input | NUM_MEM | Post strobes, memory agents |
| cacheHiReq | input | NUM_CACHE | High-priority post strobes, cache agents |
| cacheLoReq | input | NUM_CACHE | Low-priority post strobes, cache agents |
| dispHiReq | input | 1 | High-priority post strobe, display agent |
| dispLoReq | input | 1 | Low-priority post strobe, display agent |
| grantVec | output | NUM_MEM+NUM_CACHE+1 | One-hot grant by agent ID |
| grantId | output | clog2(NUM_MEM+NUM_CACHE+1) | Binary ID of granted agent |
| grantValid | output | 1 | Grant issued this cycle |
| noOp | output | 1 | Idle bus, nothing eligible |

## Verification
Two functions can fall in the same cycle. One is clearing a pending entry because it was granted. The other is posting a new request to that same entry. The bench lets a memory entry become eligible, then raises its strobe together with `busIdle`. The first arbitration must grant the entry. The arbitration right after it must be a no-op, because the new post has not yet waited long enough. A third arbitration must grant the entry again, which shows that the post was neither lost nor credited with the old wait count.

// File: rtl/bus_class_arbiter_pkg.sv
package bus_class_arbiter_pkg;

  // Winning level of one arbitration, highest priority first.
  typedef enum logic [2:0] {
    LVL_NONE,
    LVL_CACHE_HI,
    LVL_MEM,
    LVL_DISP_HI,
    LVL_CACHE_LO,
    LVL_DISP_LO
  } arbLevel_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic issue;  // a grant is taken this cycle
    logic idle;   // idle bus and nothing eligible: emit a no-op
  } arbStrobe_t;

  function automatic int ptrWidth(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/arb_wait_slot.sv
module arb_wait_slot #(
  parameter int ARB_LATENCY = 2,
  localparam int CW = (ARB_LATENCY > 0) ? $clog2(ARB_LATENCY + 1) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic post,
  input  logic clear,
  output logic eligible
);
  localparam logic [CW-1:0] LIMIT = CW'(ARB_LATENCY);

  logic          pending;
  logic [CW-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      waitCnt <= '0;
    end else if (clear) begin
      // a post that coincides with its grant opens a fresh request
      pending <= post;
      waitCnt <= '0;
    end else if (pending) begin
      if (waitCnt < LIMIT) waitCnt <= waitCnt + 1'b1;
    end else if (post) begin
      pending <= 1'b1;
      waitCnt <= '0;
    end
  end

  assign eligible = pending && (waitCnt >= LIMIT);

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N-1:0]  eligible,
  input  logic [PW-1:0] ptr,
  output logic          any,
  output logic [PW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int off = 0; off < N; off++) begin
      if (!any && eligible[(int'(ptr) + off) % N]) begin
        any = 1'b1;
        idx = PW'((int'(ptr) + off) % N);
      end
    end
  end
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import bus_class_arbiter_pkg::*;
#(
  parameter int NUM_MEM     = 2,
  parameter int NUM_CACHE   = 3,
  parameter int ARB_LATENCY = 2,
  localparam int NA  = NUM_MEM + NUM_CACHE + 1,
  localparam int NP  = NUM_MEM + 2 * NUM_CACHE + 2,
  localparam int IDW = $clog2(NA)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NP-1:0]  postVec,
  input  logic [NP-1:0]  clearVec,
  input  arbStrobe_t     strobe,
  input  logic [IDW-1:0] winnerId,
  output logic [NP-1:0]  eligVec,
  output logic [NA-1:0]  grantVec,
  output logic [IDW-1:0] grantId,
  output logic           grantValid,
  output logic           noOp
);

  for (genvar e = 0; e < NP; e++) begin : g_slot
    arb_wait_slot #(.ARB_LATENCY(ARB_LATENCY)) u_slot (
      .clk      (clk),
      .rstN     (rstN),
      .post     (postVec[e]),
      .clear    (clearVec[e]),
      .eligible (eligVec[e])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantVec   <= '0;
      grantId    <= '0;
      grantValid <= 1'b0;
      noOp       <= 1'b0;
    end else begin
      grantValid <= strobe.issue;
      noOp       <= strobe.idle;
      grantId    <= strobe.issue ? winnerId : '0;
      grantVec   <= strobe.issue ? (NA'(1) << winnerId) : '0;
    end
  end

endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import bus_class_arbiter_pkg::*;
#(
  parameter int NUM_MEM   = 2,
  parameter int NUM_CACHE = 3,
  localparam int NA  = NUM_MEM + NUM_CACHE + 1,
  localparam int NP  = NUM_MEM + 2 * NUM_CACHE + 2,
  localparam int IDW = $clog2(NA),
  localparam int MPW = ptrWidth(NUM_MEM),
  localparam int CPW = ptrWidth(NUM_CACHE),
  // entry layout: memories, cache-high, cache-low, display-high, display-low
  localparam int CH_BASE = NUM_MEM,
  localparam int CL_BASE = NUM_MEM + NUM_CACHE,
  localparam int DH_POS  = NUM_MEM + 2 * NUM_CACHE,
  localparam int DL_POS  = DH_POS + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           busIdle,
  input  logic [NP-1:0]  eligVec,
  output arbStrobe_t     strobe,
  output logic [IDW-1:0] winnerId,
  output logic [NP-1:0]  clearVec
);

  logic [MPW-1:0] memPtr, memIdx;
  logic [CPW-1:0] chPtr, chIdx, clPtr, clIdx;
  logic           memAny, chAny, clAny;
  arbLevel_t      lvl;
  logic [NP-1:0]  pickVec;

  arb_rr_pick #(.N(NUM_MEM), .PW(MPW)) u_pickMem (
    .eligible (eligVec[NUM_MEM-1:0]),
    .ptr      (memPtr),
    .any      (memAny),
    .idx      (memIdx)
  );

  arb_rr_pick #(.N(NUM_CACHE), .PW(CPW)) u_pickCacheHi (
    .eligible (eligVec[CH_BASE +: NUM_CACHE]),
    .ptr      (chPtr),
    .any      (chAny),
    .idx      (chIdx)
  );

  arb_rr_pick #(.N(NUM_CACHE), .PW(CPW)) u_pickCacheLo (
    .eligible (eligVec[CL_BASE +: NUM_CACHE]),
    .ptr      (clPtr),
    .any      (clAny),
    .idx      (clIdx)
  );

  always_comb begin
    if (chAny)              lvl = LVL_CACHE_HI;
    else if (memAny)        lvl = LVL_MEM;
    else if (eligVec[DH_POS]) lvl = LVL_DISP_HI;
    else if (clAny)         lvl = LVL_CACHE_LO;
    else if (eligVec[DL_POS]) lvl = LVL_DISP_LO;
    else                    lvl = LVL_NONE;
  end

  always_comb begin
    winnerId = '0;
    pickVec  = '0;
    case (lvl)
      LVL_CACHE_HI: begin
        winnerId = IDW'(NUM_MEM) + IDW'(chIdx);
        pickVec  = NP'(1) << (CH_BASE + int'(chIdx));
      end
      LVL_MEM: begin
        winnerId = IDW'(memIdx);
        pickVec  = NP'(1) << int'(memIdx);
      end
      LVL_DISP_HI: begin
        winnerId = IDW'(NA - 1);
        pickVec  = NP'(1) << DH_POS;
      end
      LVL_CACHE_LO: begin
        winnerId = IDW'(NUM_MEM) + IDW'(clIdx);
        pickVec  = NP'(1) << (CL_BASE + int'(clIdx));
      end
      LVL_DISP_LO: begin
        winnerId = IDW'(NA - 1);
        pickVec  = NP'(1) << DL_POS;
      end
      default: ;
    endcase
  end

  assign strobe.issue = busIdle && (lvl != LVL_NONE);
  assign strobe.idle  = busIdle && (lvl == LVL_NONE);
  assign clearVec     = strobe.issue ? pickVec : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memPtr <= '0;
      chPtr  <= '0;
      clPtr  <= '0;
    end else if (strobe.issue) begin
      case (lvl)
        LVL_MEM:      memPtr <= (int'(memIdx) == NUM_MEM - 1)   ? '0 : memIdx + 1'b1;
        LVL_CACHE_HI: chPtr  <= (int'(chIdx)  == NUM_CACHE - 1) ? '0 : chIdx + 1'b1;
        LVL_CACHE_LO: clPtr  <= (int'(clIdx)  == NUM_CACHE - 1) ? '0 : clIdx + 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bus_class_arbiter.sv
module bus_class_arbiter
  import bus_class_arbiter_pkg::*;
#(
  parameter int NUM_MEM     = 2,
  parameter int NUM_CACHE   = 3,
  parameter int ARB_LATENCY = 2,
  localparam int NA  = NUM_MEM + NUM_CACHE + 1,
  localparam int NP  = NUM_MEM + 2 * NUM_CACHE + 2,
  localparam int IDW = $clog2(NA)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busIdle,
  input  logic [NUM_MEM-1:0]   memReq,
  input  logic [NUM_CACHE-1:0] cacheHiReq,
  input  logic [NUM_CACHE-1:0] cacheLoReq,
  input  logic                 dispHiReq,
  input  logic                 dispLoReq,
  output logic [NA-1:0]        grantVec,
  output logic [IDW-1:0]       grantId,
  output logic                 grantValid,
  output logic                 noOp
);

  logic [NP-1:0]  postVec, clearVec, eligVec;
  logic [IDW-1:0] winnerId;
  arbStrobe_t     strobe;

  assign postVec = {dispLoReq, dispHiReq, cacheLoReq, cacheHiReq, memReq};

  arb_ctrl #(.NUM_MEM(NUM_MEM), .NUM_CACHE(NUM_CACHE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busIdle  (busIdle),
    .eligVec  (eligVec),
    .strobe   (strobe),
    .winnerId (winnerId),
    .clearVec (clearVec)
  );

  arb_datapath #(
    .NUM_MEM(NUM_MEM), .NUM_CACHE(NUM_CACHE), .ARB_LATENCY(ARB_LATENCY)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .postVec    (postVec),
    .clearVec   (clearVec),
    .strobe     (strobe),
    .winnerId   (winnerId),
    .eligVec    (eligVec),
    .grantVec   (grantVec),
    .grantId    (grantId),
    .grantValid (grantValid),
    .noOp       (noOp)
  );

endmodule

// File: rtl/bus_class_arbiter_chk.sv
module bus_class_arbiter_chk #(
  parameter int NUM_MEM     = 2,
  parameter int NUM_CACHE   = 3,
  parameter int ARB_LATENCY = 2,
  localparam int NA  = NUM_MEM + NUM_CACHE + 1,
  localparam int IDW = $clog2(NA)
) (
  input logic           clk,
  input logic           rstN,
  input logic           busIdle,
  input logic [NA-1:0]  grantVec,
  input logic [IDW-1:0] grantId,
  input logic           grantValid,
  input logic           noOp
);

  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> ($countones(grantVec) == 1));

  p_id_matches_vec_r1: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> grantVec[grantId]);

  p_noop_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    noOp |-> (!grantValid && (grantVec == '0)));

  p_result_needs_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid || noOp) |-> $past(busIdle));

  p_quiet_vec_r8: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> (grantVec == '0));

endmodule

bind bus_class_arbiter bus_class_arbiter_chk #(
  .NUM_MEM(NUM_MEM), .NUM_CACHE(NUM_CACHE), .ARB_LATENCY(ARB_LATENCY)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busIdle    (busIdle),
  .grantVec   (grantVec),
  .grantId    (grantId),
  .grantValid (grantValid),
  .noOp       (noOp)
);

// File: tb/bus_class_arbiter_test.sv
module bus_class_arbiter_test;
  localparam int NM  = 2;
  localparam int NC  = 3;
  localparam int LAT = 2;
  localparam int NA  = NM + NC + 1;
  localparam int IDW = $clog2(NA);
  localparam int NOOP = -1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busIdle = 1'b0;
  logic [NM-1:0] memReq = '0;
  logic [NC-1:0] cacheHiReq = '0;
  logic [NC-1:0] cacheLoReq = '0;
  logic          dispHiReq = 1'b0;
  logic          dispLoReq = 1'b0;
  logic [NA-1:0] grantVec;
  logic [IDW-1:0] grantId;
  logic          grantValid;
  logic          noOp;

  int    compared = 0;
  int    mismatched = 0;
  int    expQ[$];
  string tagQ[$];
  bit    finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  bus_class_arbiter #(.NUM_MEM(NM), .NUM_CACHE(NC), .ARB_LATENCY(LAT)) uut (
    .clk(clk), .rstN(rstN), .busIdle(busIdle),
    .memReq(memReq), .cacheHiReq(cacheHiReq), .cacheLoReq(cacheLoReq),
    .dispHiReq(dispHiReq), .dispLoReq(dispLoReq),
    .grantVec(grantVec), .grantId(grantId), .grantValid(grantValid), .noOp(noOp)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per result the design emits
  always @(negedge clk) begin
    int act;
    int e;
    string t;
    if (rstN && !finished && (grantValid || noOp)) begin
      act = noOp ? NOOP : int'(grantId);
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected result", act, -2);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(act == e, t, act, e);
        if (e != NOOP)
          check(grantVec == (NA'(1) << e), {t, " R10 vector"}, int'(grantVec), 1 << e);
      end
    end
  end

  // one-cycle post strobes, then enough cycles to become eligible
  task automatic post(input logic [NM-1:0] m, input logic [NC-1:0] ch,
                      input logic [NC-1:0] cl, input logic dh, input logic dl);
    @(negedge clk);
    memReq = m; cacheHiReq = ch; cacheLoReq = cl; dispHiReq = dh; dispLoReq = dl;
    @(negedge clk);
    memReq = '0; cacheHiReq = '0; cacheLoReq = '0; dispHiReq = 1'b0; dispLoReq = 1'b0;
    repeat (LAT + 1) @(negedge clk);
  endtask

  // one idle cycle; the expected result is queued for the monitor
  task automatic arb(input int e, input string tag);
    @(negedge clk);
    expQ.push_back(e);
    tagQ.push_back(tag);
    busIdle = 1'b1;
    @(negedge clk);
    busIdle = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(grantVec == '0 && !grantValid && !noOp && grantId == '0,
          "R9 outputs in reset", int'(grantVec), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(grantVec == '0 && !grantValid && !noOp, "R9 outputs after reset", int'(grantVec), 0);

    // empty arbitration
    arb(NOOP, "R7 no-op on empty");
    @(negedge clk);
    check(!noOp, "R7 no-op lasts one cycle", int'(noOp), 0);

    // priority across all five levels: cacheHi agent4, mem1, dispHi, cacheLo agent3, dispLo
    post(2'b10, 3'b100, 3'b010, 1'b1, 1'b1);
    arb(4, "R2 cache-high first");
    arb(1, "R2 memory second");
    arb(5, "R2 display-high third");
    arb(3, "R2 cache-low fourth");
    arb(5, "R2 display-low last");
    arb(NOOP, "R6 granted entries cleared");

    // memory rotation: mem pointer is 0 after the wrap above
    post(2'b01, '0, '0, 1'b0, 1'b0);
    arb(0, "R3 memory from pointer 0");
    post(2'b11, '0, '0, 1'b0, 1'b0);
    arb(1, "R4 memory pointer advanced to 1");
    arb(0, "R3 memory wraps to 0");

    // cache-low pointer is 2: order 4,2,3
    post('0, '0, 3'b111, 1'b0, 1'b0);
    arb(4, "R3 cache-low starts at pointer 2");
    arb(2, "R3 cache-low wraps to first cache");
    arb(3, "R3 cache-low next");
    // cache-high pointer unaffected by cache-low grants (still 0)
    post('0, 3'b011, '0, 1'b0, 1'b0);
    arb(2, "R4 cache-high pointer untouched");
    arb(3, "R4 cache-high next");

    // latency: strobe and idle together, idle held
    @(negedge clk);
    memReq = 2'b01;
    busIdle = 1'b1;
    expQ.push_back(NOOP); tagQ.push_back("R5 wait 0");
    expQ.push_back(NOOP); tagQ.push_back("R5 wait 1");
    expQ.push_back(NOOP); tagQ.push_back("R5 wait 2");
    expQ.push_back(0);    tagQ.push_back("R5 grant after latency");
    @(negedge clk);
    memReq = '0;
    @(negedge clk);
    @(negedge clk);
    check(!grantValid, "R5 no grant before latency", int'(grantValid), 0);
    @(negedge clk);
    check(grantValid && grantId == 0, "R5 grant at latency+1", int'(grantValid), 1);
    busIdle = 1'b0;

    // busy bus keeps pending entries and outputs quiet
    post('0, 3'b010, '0, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    check(!grantValid && !noOp, "R8 quiet while busy", int'(grantValid), 0);
    arb(3, "R8 pending kept through busy bus");

    // grant and re-post of the same entry in one cycle
    post(2'b01, '0, '0, 1'b0, 1'b0);
    @(negedge clk);
    expQ.push_back(0); tagQ.push_back("R11 grant on collision");
    busIdle = 1'b1;
    memReq = 2'b01;
    @(negedge clk);
    busIdle = 1'b0;
    memReq = '0;
    arb(NOOP, "R11 re-post starts fresh wait");
    arb(0, "R11 re-post retained");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R6 all expected results seen", expQ.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #80000;
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule